// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Sequencer

This block is a hardware master for a small serial EEPROM that uses a select line, a serial clock, a data line into the memory and a data line out of it. The host hands over one command at a time: a command kind, an address, optional write data, the number of data bits to send, the number of bits to read back, and whether to poll for the end of an internal program or erase cycle. The block builds the command header, drives the select, the clock and the outgoing data bit by bit, collects read data, and runs a bounded ready poll.

Every interface timing (select setup, select low time, clock high time, clock low time, data setup) is one time unit. A time unit is a parameter counted in system clocks, so one build meets slow and fast memories alike. The host sees a start/busy/done handshake. The result (read data and a timeout flag) is registered and held until the next command ends.

Top module: `mw_eeprom_seq`

## Requirements
- R1: The header is ADDR_W+3 bits, sent first, MSB first. Its top bit is a 1, the next two bits are the opcode and the low ADDR_W bits are the address. The opcode is 10 for read (cmd_kind 0), 01 for write (1) and 11 for erase (2). The extended kinds use opcode 00, the two top address bits select the operation, and the remaining address bits are zero: 11 write enable (3), 00 write disable (4, and also the unused kind 7), 01 write all (5), 10 erase all (6).
- R2: After the header, the low wr_len bits of wdata are sent MSB first. Each bit lasts three time units: the bit is placed on ee_do with ee_sk low, then ee_sk is high for one unit, then ee_sk is low for one unit, with ee_do held throughout.
- R3: ee_cs rises in the cycle after start is accepted and stays high for one time unit before the first bit is placed. At the end of every command ee_cs is low for one time unit before done. While idle, ee_cs, ee_sk and ee_do are low.
- R4: When rd_len is nonzero, one dummy clock pulse (one unit high, one unit low) follows the last sent bit. Then come rd_len pulses of the same shape, and ee_di is sampled at the end of each low unit. The bits are packed MSB first into the low rd_len bits of rdata, with the upper bits zero. ee_do keeps the last sent bit during the read pulses.
- R5: With poll_en set, the block drops ee_cs for one time unit and then raises it again. It then samples ee_di at the end of each following time unit. A high sample ends the poll with err=0. If POLL_MAX samples are all low, the command ends with err=1. Without polling, err is 0.
- R6: busy is high from the cycle after acceptance until done. done is a one-cycle pulse with busy low. A start that arrives while busy, and any change of the command inputs after acceptance, has no effect on the command in progress.
- R7: During reset, ee_cs, ee_sk, ee_do, busy, done, err and rdata are all zero.
- R8: ee_sk is high only while ee_cs is high, and it idles low.
- R9: rdata and err change only in a done cycle and hold their value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, accepted when busy is low |
| cmd_kind | input | 3 | Command kind, encoding as in R1 |
| addr | input | ADDR_W | Memory address |
| wdata | input | DATA_W | Write data, right-aligned |
| wr_len | input | $clog2(DATA_W+1) | Data bits to send after the header (0..DATA_W) |
| rd_len | input | $clog2(DATA_W+1) | Data bits to read back (0..DATA_W) |
| poll_en | input | 1 | Run the ready poll after the transfer |
| ee_di | input | 1 | Serial data from the memory |
| ee_cs | output | 1 | Memory select, active high |
| ee_sk | output | 1 | Serial clock |
| ee_do | output | 1 | Serial data to the memory |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rdata | output | DATA_W | Read result, right-aligned |
| err | output | 1 | Ready-poll timeout flag |

## Verification
On every cycle, the assertions check the following: the clock never rises outside the select window; ee_do holds steady while the clock is high; clock high pulses are never shorter than two system clocks; the idle outputs stay quiet; acceptance raises busy and select together; done is a lone pulse taken with busy low; and the result registers hold between done cycles. Only the bench scenarios show the rest. These are the exact header codes for each kind, the placement of the dummy pulse, the packing of read bits, and the poll outcome for a memory that answers at once, after a delay or never. They also show that a start raised mid-command leaves the serial trace unchanged. The bench's own model checks all of these against every cycle of the waveform.

// File: rtl/mwseq_pkg.sv
package mwseq_pkg;
  // opcode field of the header
  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  // extended operation carried in the top two address bits
  localparam logic [1:0] EXT_WRDIS = 2'b00;
  localparam logic [1:0] EXT_FILL  = 2'b01;
  localparam logic [1:0] EXT_CLEAR = 2'b10;
  localparam logic [1:0] EXT_WREN  = 2'b11;

  // host command kinds
  localparam logic [2:0] KIND_READ  = 3'd0;
  localparam logic [2:0] KIND_WRITE = 3'd1;
  localparam logic [2:0] KIND_ERASE = 3'd2;
  localparam logic [2:0] KIND_WREN  = 3'd3;
  localparam logic [2:0] KIND_WRDIS = 3'd4;
  localparam logic [2:0] KIND_FILL  = 3'd5;
  localparam logic [2:0] KIND_CLEAR = 3'd6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_WSET, ST_WHI, ST_WLO,
    ST_RHI, ST_RLO, ST_PDESEL, ST_PWAIT, ST_FIN
  } seq_state_e;
endpackage

// File: rtl/mwseq_encode.sv
module mwseq_encode #(
  parameter int ADDR_W = 7
) (
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W+2:0] hdr
);
  import mwseq_pkg::*;

  logic [1:0]        opc;
  logic [ADDR_W-1:0] abits;

  always_comb begin
    opc   = OPC_EXT;
    abits = '0;
    case (kind)
      KIND_READ:  begin opc = OPC_READ;  abits = addr; end
      KIND_WRITE: begin opc = OPC_WRITE; abits = addr; end
      KIND_ERASE: begin opc = OPC_ERASE; abits = addr; end
      KIND_WREN:  abits[ADDR_W-1 -: 2] = EXT_WREN;
      KIND_FILL:  abits[ADDR_W-1 -: 2] = EXT_FILL;
      KIND_CLEAR: abits[ADDR_W-1 -: 2] = EXT_CLEAR;
      default:    abits[ADDR_W-1 -: 2] = EXT_WRDIS;
    endcase
    hdr = {1'b1, opc, abits};
  end
endmodule

// File: rtl/mwseq_tick.sv
module mwseq_tick #(
  parameter int TU_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic last
);
  localparam int CW = (TU_CYC > 1) ? $clog2(TU_CYC) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= CW'(TU_CYC - 1);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/mwseq_txshift.sv
module mwseq_txshift #(
  parameter int FRAME_W = 26,
  parameter int FCW     = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] frame,
  input  logic [FCW-1:0]     nbits,
  output logic               msb,
  output logic               empty
);
  logic [FRAME_W-1:0] sr;
  logic [FCW-1:0]     left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= frame;
      left <= nbits;
    end else if (shift) begin
      sr   <= {sr[FRAME_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign msb   = sr[FRAME_W-1];
  assign empty = (left == '0);
endmodule

// File: rtl/mwseq_rxshift.sv
module mwseq_rxshift #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              shift,
  input  logic              din,
  output logic [DATA_W-1:0] data,
  output logic              empty,
  output logic              one_left
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      left <= '0;
    end else if (load) begin
      data <= '0;
      left <= nbits;
    end else if (shift) begin
      data <= {data[DATA_W-2:0], din};
      left <= left - 1'b1;
    end
  end

  assign empty    = (left == '0);
  assign one_left = (left == CNT_W'(1));
endmodule

// File: rtl/mw_eeprom_seq.sv
module mw_eeprom_seq #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int TU_CYC   = 4,
  parameter int POLL_MAX = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [2:0]                  cmd_kind,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [$clog2(DATA_W+1)-1:0] wr_len,
  input  logic [$clog2(DATA_W+1)-1:0] rd_len,
  input  logic                        poll_en,
  input  logic                        ee_di,
  output logic                        ee_cs,
  output logic                        ee_sk,
  output logic                        ee_do,
  output logic                        busy,
  output logic                        done,
  output logic [DATA_W-1:0]           rdata,
  output logic                        err
);
  import mwseq_pkg::*;

  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam int HDR_W   = ADDR_W + 3;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int FCW     = $clog2(FRAME_W + 1);
  localparam int PW      = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

  seq_state_e state, nxt;

  logic              last, tick_load, accept;
  logic              tx_shift, tx_msb, tx_empty;
  logic              rx_shift, rx_empty, rx_one_left;
  logic [DATA_W-1:0] rx_data;
  logic [HDR_W-1:0]  hdr;
  logic [CNT_W-1:0]  pad;
  logic [DATA_W-1:0] data_al;
  logic [FRAME_W-1:0] frame;
  logic [FCW-1:0]    nbits;

  logic              cs_q, sk_q, do_q, busy_q, done_q, err_q;
  logic [DATA_W-1:0] rdata_q;
  logic              dummy_q, poll_q, perr_q;
  logic [PW-1:0]     pcnt;
  seq_state_e        after_write, after_read;

  // frame: header followed by the selected data bits, left aligned
  mwseq_encode #(.ADDR_W(ADDR_W)) u_enc (
    .kind (cmd_kind),
    .addr (addr),
    .hdr  (hdr)
  );

  always_comb begin
    pad     = CNT_W'(DATA_W) - wr_len;
    data_al = wdata << pad;
    frame   = {hdr, data_al};
    nbits   = FCW'(HDR_W) + FCW'(wr_len);
  end

  mwseq_tick #(.TU_CYC(TU_CYC)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .load (tick_load),
    .last (last)
  );

  mwseq_txshift #(.FRAME_W(FRAME_W), .FCW(FCW)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .shift (tx_shift),
    .frame (frame),
    .nbits (nbits),
    .msb   (tx_msb),
    .empty (tx_empty)
  );

  mwseq_rxshift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .nbits    (rd_len),
    .shift    (rx_shift),
    .din      (ee_di),
    .data     (rx_data),
    .empty    (rx_empty),
    .one_left (rx_one_left)
  );

  // next phase after the transfer parts
  always_comb begin
    after_read  = poll_q ? ST_PDESEL : ST_FIN;
    after_write = !rx_empty ? ST_RHI : after_read;
  end

  always_comb begin
    nxt      = state;
    accept   = 1'b0;
    tx_shift = 1'b0;
    rx_shift = 1'b0;
    case (state)
      ST_IDLE:   if (start) begin nxt = ST_SETUP; accept = 1'b1; end
      ST_SETUP:  if (last) nxt = ST_WSET;
      ST_WSET:   if (last) nxt = ST_WHI;
      ST_WHI:    if (last) begin nxt = ST_WLO; tx_shift = 1'b1; end
      ST_WLO:    if (last) nxt = tx_empty ? after_write : ST_WSET;
      ST_RHI:    if (last) nxt = ST_RLO;
      ST_RLO: begin
        if (last) begin
          if (dummy_q) begin
            nxt = ST_RHI;
          end else begin
            rx_shift = 1'b1;
            nxt      = rx_one_left ? after_read : ST_RHI;
          end
        end
      end
      ST_PDESEL: if (last) nxt = ST_PWAIT;
      ST_PWAIT:  if (last && (ee_di || pcnt == PW'(POLL_MAX - 1))) nxt = ST_FIN;
      ST_FIN:    if (last) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign tick_load = accept || ((state != ST_IDLE) && last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      do_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      dummy_q <= 1'b0;
      poll_q  <= 1'b0;
      perr_q  <= 1'b0;
      pcnt    <= '0;
    end else begin
      state  <= nxt;
      cs_q   <= !(nxt inside {ST_IDLE, ST_PDESEL, ST_FIN});
      sk_q   <= (nxt == ST_WHI) || (nxt == ST_RHI);
      busy_q <= (nxt != ST_IDLE);
      done_q <= (state == ST_FIN) && (nxt == ST_IDLE);

      if (nxt == ST_WSET)                               do_q <= tx_msb;
      else if (nxt inside {ST_IDLE, ST_PDESEL, ST_FIN}) do_q <= 1'b0;

      if (accept) begin
        dummy_q <= 1'b1;
        poll_q  <= poll_en;
        perr_q  <= 1'b0;
      end else if (state == ST_RLO && last) begin
        dummy_q <= 1'b0;
      end

      if (state == ST_PDESEL) begin
        pcnt <= '0;
      end else if (state == ST_PWAIT && last) begin
        if (nxt == ST_PWAIT) pcnt <= pcnt + 1'b1;
        else if (!ee_di)     perr_q <= 1'b1;
      end

      if (state == ST_FIN && nxt == ST_IDLE) begin
        rdata_q <= rx_data;
        err_q   <= perr_q;
      end
    end
  end

  assign ee_cs = cs_q;
  assign ee_sk = sk_q;
  assign ee_do = do_q;
  assign busy  = busy_q;
  assign done  = done_q;
  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/mw_eeprom_seq_chk.sv
module mw_eeprom_seq_chk #(
  parameter int DATA_W = 16,
  parameter int TU_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_do,
  input logic [DATA_W-1:0] rdata,
  input logic              err
);
  AST_SK_UNDER_CS: assert property (@(posedge clk) disable iff (rst) ee_sk |-> ee_cs); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R6
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done); // R6
  AST_ACCEPT_SELECT: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> (busy && ee_cs)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (!ee_cs && !ee_sk && !ee_do)); // R3
  AST_DO_STEADY: assert property (@(posedge clk) disable iff (rst) ee_sk |-> $stable(ee_do)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> ($stable(rdata) && $stable(err))); // R9

  generate
    if (TU_CYC > 1) begin : g_width
      AST_SK_MIN_HIGH: assert property (@(posedge clk) disable iff (rst) $rose(ee_sk) |=> ee_sk); // R2
    end
  endgenerate
endmodule

bind mw_eeprom_seq mw_eeprom_seq_chk #(
  .DATA_W (DATA_W),
  .TU_CYC (TU_CYC)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .ee_cs (ee_cs),
  .ee_sk (ee_sk),
  .ee_do (ee_do),
  .rdata (rdata),
  .err   (err)
);

// File: tb/mw_eeprom_seq_tb.sv
module mw_eeprom_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TU   = 3;
  localparam int AW   = 7;
  localparam int DW   = 16;
  localparam int PMAX = 10;
  localparam int CW   = $clog2(DW + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    cmd_kind = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [CW-1:0] wr_len = '0;
  logic [CW-1:0] rd_len = '0;
  logic          poll_en = 1'b0;
  logic          ee_di = 1'b0;
  logic          ee_cs, ee_sk, ee_do, busy, done, err;
  logic [DW-1:0] rdata;

  int            checks = 0;
  int            errors = 0;
  bit            finished = 1'b0;
  bit            inj_req = 1'b0;
  logic [DW-1:0] exp_rdata = '0;
  logic          exp_err = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mw_eeprom_seq #(
    .ADDR_W (AW), .DATA_W (DW), .TU_CYC (TU), .POLL_MAX (PMAX)
  ) u_dut (
    .clk (clk), .rst (rst), .start (start), .cmd_kind (cmd_kind),
    .addr (addr), .wdata (wdata), .wr_len (wr_len), .rd_len (rd_len),
    .poll_en (poll_en), .ee_di (ee_di), .ee_cs (ee_cs), .ee_sk (ee_sk),
    .ee_do (ee_do), .busy (busy), .done (done), .rdata (rdata), .err (err)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // header per R1, built from the stated field positions
  function automatic logic [AW+2:0] hdr_of(input logic [2:0] k, input logic [AW-1:0] a);
    case (k)
      3'd0:    return {1'b1, 2'b10, a};
      3'd1:    return {1'b1, 2'b01, a};
      3'd2:    return {1'b1, 2'b11, a};
      3'd3:    return {1'b1, 2'b00, 2'b11, 5'b0};
      3'd5:    return {1'b1, 2'b00, 2'b01, 5'b0};
      3'd6:    return {1'b1, 2'b00, 2'b10, 5'b0};
      default: return {1'b1, 2'b00, 2'b00, 5'b0};
    endcase
  endfunction

  // one clock of the reference trace, compared away from the active edge
  task automatic cycle(input bit cs, input bit sk, input bit dv, input bit bsy,
                       input bit dn, input string tag);
    @(negedge clk);
    start = inj_req;
    if (inj_req) begin
      cmd_kind = 3'd2;
      addr     = '1;
    end
    inj_req = 1'b0;
    check({ee_cs, ee_sk, ee_do, busy, done} == {cs, sk, dv, bsy, dn}, tag,
          "cs/sk/do/busy/done", {ee_cs, ee_sk, ee_do, busy, done}, {cs, sk, dv, bsy, dn});
    check(!ee_sk || ee_cs, "R8", "sk outside select", {ee_sk, ee_cs}, 2'b00);
    check({rdata, err} == {exp_rdata, exp_err}, "R9", "result hold",
          {rdata, err}, {exp_rdata, exp_err});
  endtask

  task automatic phase(input bit cs, input bit sk, input bit dv, input bit di, input string tag);
    for (int n = 0; n < TU; n++) begin
      cycle(cs, sk, dv, 1'b1, 1'b0, tag);
      ee_di = di;
    end
  endtask

  task automatic run(input logic [2:0] k, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     input int wl, input int rl, input bit pl, input logic [DW-1:0] pat,
                     input int ready_at, input bit inject, input string tag);
    logic [AW+2:0] h;
    logic [DW-1:0] res;
    bit            dv;
    int            np;
    h = hdr_of(k, a);
    @(negedge clk);
    cmd_kind = k; addr = a; wdata = wd; wr_len = CW'(wl); rd_len = CW'(rl);
    poll_en = pl; start = 1'b1; ee_di = 1'b0;
    phase(1, 0, 0, 0, "R3");
    if (inject) inj_req = 1'b1;
    dv = 1'b0;
    for (int i = AW + 2; i >= 0; i--) begin
      dv = h[i];
      phase(1, 0, dv, 0, tag); phase(1, 1, dv, 0, tag); phase(1, 0, dv, 0, tag);
    end
    for (int i = wl - 1; i >= 0; i--) begin
      dv = wd[i];
      phase(1, 0, dv, 0, "R2"); phase(1, 1, dv, 0, "R2"); phase(1, 0, dv, 0, "R2");
    end
    res = '0;
    if (rl > 0) begin
      phase(1, 1, dv, 0, "R4"); phase(1, 0, dv, 0, "R4");
      for (int i = rl - 1; i >= 0; i--) begin
        phase(1, 1, dv, pat[i], "R4"); phase(1, 0, dv, pat[i], "R4");
        res = {res[DW-2:0], pat[i]};
      end
    end
    if (pl) begin
      phase(0, 0, 0, 0, "R5");
      np = (ready_at < PMAX) ? ready_at + 1 : PMAX;
      for (int j = 0; j < np; j++) phase(1, 0, 0, (j >= ready_at), "R5");
    end
    phase(0, 0, 0, 0, "R3");
    exp_rdata = res;
    exp_err   = pl && (ready_at >= PMAX);
    cycle(0, 0, 0, 0, 1, "R6");
    ee_di = 1'b0;
    cycle(0, 0, 0, 0, 0, "R6");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({ee_cs, ee_sk, ee_do, busy, done, err} == 6'b0, "R7", "reset outputs",
          {ee_cs, ee_sk, ee_do, busy, done, err}, 6'b0);
    check(rdata == '0, "R7", "reset rdata", rdata, '0);
    rst = 1'b0;
    for (int n = 0; n < 2; n++) cycle(0, 0, 0, 0, 0, "R7");

    run(3'd0, 7'h5A, '0, 0, 16, 0, 16'hBEEF, 0, 0, "R1");    // read, full word
    run(3'd1, 7'h13, 16'hA5C3, 16, 0, 1, '0, 2, 0, "R1");    // write, ready after 2 polls
    run(3'd2, 7'h7F, '0, 0, 0, 1, '0, 0, 0, "R5");           // erase, ready at once
    run(3'd5, 7'h00, 16'h003C, 8, 0, 1, '0, 99, 0, "R5");    // write all, timeout
    run(3'd3, 7'h1F, '0, 0, 0, 0, '0, 0, 0, "R1");           // write enable
    run(3'd4, 7'h7F, '0, 0, 0, 0, '0, 0, 0, "R1");           // write disable
    run(3'd6, 7'h55, '0, 0, 0, 0, '0, 0, 0, "R1");           // erase all
    run(3'd0, 7'h21, '0, 0, 8, 0, 16'hFF81, 0, 1, "R6");     // start ignored mid-command
    run(3'd7, 7'h7F, '0, 0, 1, 0, 16'h0001, 0, 0, "R1");     // unused kind, 1-bit read
    run(3'd0, 7'h02, '0, 0, 3, 1, 16'h0005, 9, 0, "R4");     // read then last-chance poll

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=busy expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule